// File: doc/BRIEF.md
# Indirect Shared Register Access Bridge

This block lets a host register bus reach a small bank of always-on shared registers through two 32-bit window registers: a control word and a data word. The host puts a target byte offset and an operation code into the control word, and values move through the data word. Accesses through the windows need no wake-up or grant handshake. They work the same way whether the main MAC power domain is up or down.

A fixed-priority arbiter sits in front of the bank. It serves the window path and a second requester from the MAC domain. The MAC requester is masked whenever its power-good input is low. The bank holds a set of general-purpose registers and a crystal configuration register. That register has a low-power enable, a persistence flag and a trim field. The persistence flag decides whether the low-power enable survives a shared-block reset.

Top module: `shr_window_bridge`

## Requirements
- R1: After rst_ni is released, both windows read 0 and hready_o is 1. Every general-purpose register reads 0. The crystal register reads 0x00000800, meaning low-power enable off, persistence off and trim 8.
- R2: The host can write a shared register in two steps. It first writes the value to the data window at host offset 0xF4. It then writes the control window at host offset 0xEC with the target byte offset in bits [15:0] and operation 3 in bits [29:28]. The second write commits the held data to the target.
- R3: The host can read a shared register in two steps. It writes the control window with operation 2 in bits [29:28] and the target offset in bits [15:0]. A later read of the data window returns the target's value.
- R4: After any control write that carries operation 2 or 3, hready_o is low for exactly the next cycle and high again in the cycle after that. A read of the data window is therefore held off until the read data has been latched.
- R5: Operation codes 0 and 1 leave the shared bank and the data window unchanged. Before any read operation, the data window returns the last value latched into it.
- R6: A shared read of an offset that matches no implemented register returns 0, and a write to such an offset is dropped. Misaligned offsets count as unmatched.
- R7: While mac_pwr_good_i is low, mac_gnt_o stays 0 and MAC-side writes have no effect. Window accesses work exactly as they do with power good.
- R8: A pending window operation wins the bank over a MAC request in the same cycle. Otherwise a MAC request with power good is granted in the cycle it is made. A granted MAC write updates the register, and a granted MAC read returns the data on mac_rdata_o in that same cycle.
- R9: The crystal register sits at shared offset 0x1D0. Bit 0 is the low-power enable, bit 1 is persistence, and bits [11:8] are trim. All other bits read 0. The general-purpose registers sit at 0x1DC and 0x1E0.
- R10: A shared-block reset (shr_rst_i) clears the general-purpose registers and restores trim to 8. If persistence is set, the low-power enable and persistence keep their values. If persistence is clear, both are cleared.
- R11: A read of the control window returns the last full 32-bit word written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous full device reset |
| shr_rst_i | input | 1 | Synchronous shared-block reset |
| hreq_i | input | 1 | Host access valid |
| hwe_i | input | 1 | Host write (1) or read (0) |
| haddr_i | input | HOST_AW | Host byte offset |
| hwdata_i | input | 32 | Host write data |
| hrdata_o | output | 32 | Host read data |
| hready_o | output | 1 | Host access accepted this cycle |
| mac_pwr_good_i | input | 1 | MAC power domain is up |
| mac_req_i | input | 1 | MAC-side bank request |
| mac_we_i | input | 1 | MAC-side write (1) or read (0) |
| mac_addr_i | input | 16 | MAC-side shared byte offset |
| mac_wdata_i | input | 32 | MAC-side write data |
| mac_gnt_o | output | 1 | MAC request granted this cycle |
| mac_rdata_o | output | 32 | MAC-side read data, valid with grant |

## Verification
The bench builds the block with its default parameters: windows at 0xEC and 0xF4, two general-purpose registers from 0x1DC, the crystal register at 0x1D0 and trim reset 8. With these values the windows, the crystal field layout, a hole at 0x1D4 between mapped registers, a misaligned offset and an offset far outside the map can all be reached. The vector table is walked with MAC power off, which shows that window access does not depend on it. The directed tests then power the MAC side up to collide a MAC request with a pending window operation and to exercise both persistence outcomes of a shared reset.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int SHR_AW = 16;
  localparam int SHR_DW = 32;

  localparam int CTL_OFS_LSB = 0;
  localparam int CTL_OP_LSB  = 28;
  localparam int CTL_OP_MSB  = 29;

  localparam int XT_LP_BIT   = 0;
  localparam int XT_PERS_BIT = 1;
  localparam int XT_TRIM_LSB = 8;
  localparam int XT_TRIM_W   = 4;

  typedef enum logic [1:0] {
    OP_IDLE_A = 2'd0,
    OP_IDLE_B = 2'd1,
    OP_READ   = 2'd2,
    OP_WRITE  = 2'd3
  } shr_op_e;

  typedef struct packed {
    logic              we;
    logic [SHR_AW-1:0] addr;
    logic [SHR_DW-1:0] wdata;
  } shr_req_t;
endpackage

// File: rtl/shr_host_window.sv
module shr_host_window
  import shr_pkg::*;
#(
  parameter int               HOST_AW  = 8,
  parameter logic [HOST_AW-1:0] CTRL_OFS = 8'hEC,
  parameter logic [HOST_AW-1:0] DATA_OFS = 8'hF4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hreq_i,
  input  logic               hwe_i,
  input  logic [HOST_AW-1:0] haddr_i,
  input  logic [SHR_DW-1:0]  hwdata_i,
  output logic [SHR_DW-1:0]  hrdata_o,
  output logic               hready_o,
  output logic               req_v_o,
  output shr_req_t           req_o,
  input  logic               gnt_i,
  input  logic [SHR_DW-1:0]  rdata_i
);
  logic [SHR_DW-1:0] ctrl_q, data_q;
  logic              pend_q, pend_we_q;
  logic              acc, ctrl_wr, data_wr;
  shr_op_e           op_w;

  assign acc     = hreq_i && !pend_q;
  assign ctrl_wr = acc && hwe_i && (haddr_i == CTRL_OFS);
  assign data_wr = acc && hwe_i && (haddr_i == DATA_OFS);
  assign op_w    = shr_op_e'(hwdata_i[CTL_OP_MSB:CTL_OP_LSB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      data_q    <= '0;
      pend_q    <= 1'b0;
      pend_we_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q    <= hwdata_i;
        pend_q    <= (op_w == OP_READ) || (op_w == OP_WRITE);
        pend_we_q <= (op_w == OP_WRITE);
      end else if (pend_q && gnt_i) begin
        pend_q <= 1'b0;
        if (!pend_we_q) data_q <= rdata_i;
      end
      if (data_wr) data_q <= hwdata_i;
    end
  end

  assign req_v_o     = pend_q;
  assign req_o.we    = pend_we_q;
  assign req_o.addr  = ctrl_q[CTL_OFS_LSB +: SHR_AW];
  assign req_o.wdata = data_q;
  assign hready_o    = !pend_q;

  always_comb begin
    hrdata_o = '0;
    if (acc && !hwe_i) begin
      if (haddr_i == CTRL_OFS)      hrdata_o = ctrl_q;
      else if (haddr_i == DATA_OFS) hrdata_o = data_q;
    end
  end

  AST_PEND_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && gnt_i |=> !pend_q && hready_o); // R4
  AST_IDLE_OP_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && (op_w == OP_IDLE_A || op_w == OP_IDLE_B) |=> !req_v_o); // R5
endmodule

// File: rtl/shr_arbiter.sv
module shr_arbiter
  import shr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     host_v_i,
  input  shr_req_t host_req_i,
  input  logic     mac_v_i,
  input  shr_req_t mac_req_i,
  input  logic     pwr_good_i,
  output logic     host_gnt_o,
  output logic     mac_gnt_o,
  output logic     bank_v_o,
  output shr_req_t bank_req_o
);
  logic mac_live;

  assign mac_live   = mac_v_i && pwr_good_i;
  assign host_gnt_o = host_v_i;
  assign mac_gnt_o  = mac_live && !host_v_i;
  assign bank_v_o   = host_v_i || mac_live;
  assign bank_req_o = host_v_i ? host_req_i : mac_req_i;

  AST_MAC_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> !mac_gnt_o); // R7
  AST_HOST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_v_i |-> host_gnt_o && !mac_gnt_o); // R8
endmodule

// File: rtl/shr_reg_bank.sv
module shr_reg_bank
  import shr_pkg::*;
#(
  parameter logic [SHR_AW-1:0]    GP_BASE  = 16'h01DC,
  parameter int                   GP_NUM   = 2,
  parameter logic [SHR_AW-1:0]    XTAL_OFS = 16'h01D0,
  parameter logic [XT_TRIM_W-1:0] TRIM_RST = 4'h8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shr_rst_i,
  input  logic              acc_v_i,
  input  shr_req_t          req_i,
  output logic [SHR_DW-1:0] rdata_o
);
  localparam int GP_STRIDE = SHR_DW / 8;

  logic [GP_NUM-1:0]    gp_hit;
  logic [SHR_DW-1:0]    gp_rd [GP_NUM];
  logic                 xt_hit, lp_q, pers_q;
  logic [XT_TRIM_W-1:0] trim_q;
  logic [SHR_DW-1:0]    xt_rd;

  for (genvar g = 0; g < GP_NUM; g++) begin : g_gp
    logic [SHR_DW-1:0] val_q;
    assign gp_hit[g] = (req_i.addr == GP_BASE + SHR_AW'(g * GP_STRIDE));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          val_q <= '0;
      else if (shr_rst_i)                   val_q <= '0;
      else if (acc_v_i && req_i.we && gp_hit[g]) val_q <= req_i.wdata;
    end
    assign gp_rd[g] = gp_hit[g] ? val_q : '0;
  end

  assign xt_hit = (req_i.addr == XTAL_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q   <= 1'b0;
      pers_q <= 1'b0;
      trim_q <= TRIM_RST;
    end else if (shr_rst_i) begin
      trim_q <= TRIM_RST;
      if (!pers_q) lp_q <= 1'b0;
    end else if (acc_v_i && req_i.we && xt_hit) begin
      lp_q   <= req_i.wdata[XT_LP_BIT];
      pers_q <= req_i.wdata[XT_PERS_BIT];
      trim_q <= req_i.wdata[XT_TRIM_LSB +: XT_TRIM_W];
    end
  end

  always_comb begin
    xt_rd = '0;
    if (xt_hit) begin
      xt_rd[XT_LP_BIT]                  = lp_q;
      xt_rd[XT_PERS_BIT]                = pers_q;
      xt_rd[XT_TRIM_LSB +: XT_TRIM_W]   = trim_q;
    end
  end

  always_comb begin
    rdata_o = xt_rd;
    for (int g = 0; g < GP_NUM; g++) rdata_o |= gp_rd[g];
  end

  AST_XTAL_PERSIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shr_rst_i && pers_q |=> lp_q == $past(lp_q) && pers_q); // R10
  AST_XTAL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shr_rst_i && !pers_q |=> !lp_q && !pers_q); // R10
endmodule

// File: rtl/shr_window_bridge.sv
module shr_window_bridge
  import shr_pkg::*;
#(
  parameter int                   HOST_AW  = 8,
  parameter logic [HOST_AW-1:0]   CTRL_OFS = 8'hEC,
  parameter logic [HOST_AW-1:0]   DATA_OFS = 8'hF4,
  parameter logic [15:0]          GP_BASE  = 16'h01DC,
  parameter int                   GP_NUM   = 2,
  parameter logic [15:0]          XTAL_OFS = 16'h01D0,
  parameter logic [3:0]           TRIM_RST = 4'h8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shr_rst_i,
  input  logic               hreq_i,
  input  logic               hwe_i,
  input  logic [HOST_AW-1:0] haddr_i,
  input  logic [31:0]        hwdata_i,
  output logic [31:0]        hrdata_o,
  output logic               hready_o,
  input  logic               mac_pwr_good_i,
  input  logic               mac_req_i,
  input  logic               mac_we_i,
  input  logic [15:0]        mac_addr_i,
  input  logic [31:0]        mac_wdata_i,
  output logic               mac_gnt_o,
  output logic [31:0]        mac_rdata_o
);
  logic        win_v, win_gnt, bank_v;
  shr_req_t    win_req, mac_req, bank_req;
  logic [31:0] bank_rdata;

  assign mac_req.we    = mac_we_i;
  assign mac_req.addr  = mac_addr_i;
  assign mac_req.wdata = mac_wdata_i;

  shr_host_window #(.HOST_AW(HOST_AW), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)) u_win (
    .clk_i, .rst_ni, .hreq_i, .hwe_i, .haddr_i, .hwdata_i, .hrdata_o, .hready_o,
    .req_v_o(win_v), .req_o(win_req), .gnt_i(win_gnt), .rdata_i(bank_rdata)
  );

  shr_arbiter u_arb (
    .clk_i, .rst_ni,
    .host_v_i(win_v), .host_req_i(win_req),
    .mac_v_i(mac_req_i), .mac_req_i(mac_req), .pwr_good_i(mac_pwr_good_i),
    .host_gnt_o(win_gnt), .mac_gnt_o(mac_gnt_o),
    .bank_v_o(bank_v), .bank_req_o(bank_req)
  );

  shr_reg_bank #(.GP_BASE(GP_BASE), .GP_NUM(GP_NUM), .XTAL_OFS(XTAL_OFS), .TRIM_RST(TRIM_RST)) u_bank (
    .clk_i, .rst_ni, .shr_rst_i, .acc_v_i(bank_v), .req_i(bank_req), .rdata_o(bank_rdata)
  );

  assign mac_rdata_o = mac_gnt_o ? bank_rdata : '0;

  AST_MAC_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mac_pwr_good_i |-> mac_rdata_o == '0); // R7
  AST_READY_AFTER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_o |=> hready_o); // R4
endmodule

// File: tb/sim_shr_window_bridge.sv
module sim_shr_window_bridge;
  localparam logic [7:0] CTRL = 8'hEC;
  localparam logic [7:0] DATA = 8'hF4;
  localparam int NV = 6;
  // {offset, write value, expected read-back}
  localparam logic [79:0] VEC [NV] = '{
    {16'h01DC, 32'hDEADBEEF, 32'hDEADBEEF},
    {16'h01E0, 32'h12345678, 32'h12345678},
    {16'h01D0, 32'hFFFFFFFF, 32'h00000F03},
    {16'h01D4, 32'hAAAA5555, 32'h00000000},
    {16'h01DD, 32'h0BADF00D, 32'h00000000},
    {16'h0100, 32'hCAFEF00D, 32'h00000000}
  };

  logic clk = 0, rst_n = 0, shr_rst = 0;
  logic hreq = 0, hwe = 0;
  logic [7:0] haddr = '0;
  logic [31:0] hwdata = '0, hrdata;
  logic hready;
  logic pwr = 0, mreq = 0, mwe = 0;
  logic [15:0] maddr = '0;
  logic [31:0] mwdata = '0, mrdata;
  logic mgnt;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shr_window_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .shr_rst_i(shr_rst),
    .hreq_i(hreq), .hwe_i(hwe), .haddr_i(haddr), .hwdata_i(hwdata),
    .hrdata_o(hrdata), .hready_o(hready),
    .mac_pwr_good_i(pwr), .mac_req_i(mreq), .mac_we_i(mwe), .mac_addr_i(maddr),
    .mac_wdata_i(mwdata), .mac_gnt_o(mgnt), .mac_rdata_o(mrdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    while (!hready) @(negedge clk);
    hreq = 1; hwe = 1; haddr = a; hwdata = d;
    @(negedge clk);
    hreq = 0; hwe = 0;
  endtask

  task automatic hr(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    while (!hready) @(negedge clk);
    hreq = 1; hwe = 0; haddr = a;
    #1 d = hrdata;
    @(negedge clk);
    hreq = 0;
  endtask

  task automatic shr_wr(logic [15:0] ofs, logic [31:0] d);
    hw(DATA, d);
    hw(CTRL, {2'b00, 2'd3, 12'h000, ofs});
  endtask

  task automatic shr_rd(logic [15:0] ofs, output logic [31:0] d);
    hw(CTRL, {2'b00, 2'd2, 12'h000, ofs});
    hr(DATA, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 hready", {31'b0, hready}, 32'd1);
    hr(CTRL, v); chk("R1 ctrl", v, 0);
    hr(DATA, v); chk("R1/R5 data before read", v, 0);
    shr_rd(16'h01D0, v); chk("R1 xtal", v, 32'h00000800);
    shr_rd(16'h01DC, v); chk("R1 gp0", v, 0);

    // R2 R3 R6 R9 R7: table walked with MAC power off
    for (int i = 0; i < NV; i++) begin
      shr_wr(VEC[i][79:64], VEC[i][63:32]);
      shr_rd(VEC[i][79:64], v);
      chk($sformatf("R2/R3/R6/R9 vec%0d", i), v, VEC[i][31:0]);
    end
    shr_rd(16'h01DC, v); chk("R6 gp0 untouched by dropped writes", v, 32'hDEADBEEF);

    // R4 stall timing
    hw(CTRL, {4'b0010, 12'h000, 16'h01E0});
    chk("R4 ready low", {31'b0, hready}, 0);
    @(negedge clk);
    chk("R4 ready back", {31'b0, hready}, 1);
    hr(DATA, v); chk("R4 data latched", v, 32'h12345678);

    // R5 idle ops, R11 ctrl readback
    hw(DATA, 32'h00001234);
    hw(CTRL, {4'b0000, 12'h000, 16'h01DC});
    hw(CTRL, {4'b0001, 12'h000, 16'h01DC});
    hr(DATA, v); chk("R5 data kept", v, 32'h00001234);
    hr(CTRL, v); chk("R11 ctrl readback", v, 32'h100001DC);
    shr_rd(16'h01DC, v); chk("R5 gp0 unchanged", v, 32'hDEADBEEF);

    // R7 MAC masked while power low
    @(negedge clk);
    mreq = 1; mwe = 1; maddr = 16'h01DC; mwdata = 32'h0000BAD0;
    #1 chk("R7 no grant", {31'b0, mgnt}, 0);
    @(negedge clk); mreq = 0;
    shr_rd(16'h01DC, v); chk("R7 no MAC write", v, 32'hDEADBEEF);

    // R8 MAC served with power, host priority
    pwr = 1;
    @(negedge clk);
    mreq = 1; mwe = 1; maddr = 16'h01E0; mwdata = 32'h00000055;
    #1 chk("R8 grant", {31'b0, mgnt}, 1);
    @(negedge clk); mreq = 0; mwe = 0;
    hw(CTRL, {4'b0010, 12'h000, 16'h01DC});
    mreq = 1; maddr = 16'h01E0;
    #1 chk("R8 host wins", {31'b0, mgnt}, 0);
    @(negedge clk);
    #1 chk("R8 grant after host", {31'b0, mgnt}, 1);
    chk("R8 mac rdata", mrdata, 32'h00000055);
    @(negedge clk); mreq = 0;
    hr(DATA, v); chk("R8 host read result", v, 32'hDEADBEEF);

    // R10 shared reset with persistence set
    shr_wr(16'h01D0, 32'h00000303);
    @(negedge clk); shr_rst = 1; @(negedge clk); shr_rst = 0;
    shr_rd(16'h01D0, v); chk("R10 persist kept", v, 32'h00000803);
    shr_rd(16'h01DC, v); chk("R10 gp cleared", v, 0);
    // R10 without persistence
    shr_wr(16'h01D0, 32'h00000001);
    @(negedge clk); shr_rst = 1; @(negedge clk); shr_rst = 0;
    shr_rd(16'h01D0, v); chk("R10 lp cleared", v, 32'h00000800);

    finish_run();
  end
endmodule